// File: doc/BRIEF.md
# Command Packet Issuer with Register Queue

This block sends one display-link command packet at a time. Software fills a small queue of 32-bit words through a register write port and sets the queue size. It then toggles the start bit from 0 to 1. The block reads the first queue word and decides from its low byte whether the packet is short or long, and whether it ends with a bus turnaround that asks the peripheral for a response. It then streams the packet out one byte per clock: identifier, two argument bytes, and for long packets the payload taken from the following queue words.

While a packet is in flight, and until software acknowledges it, the block reports busy. A finished transmission sets a done flag. For a read, the response bytes that come back on the receive stream are captured into a 16-byte buffer, and a read-ready flag is set once the response has ended. Software clears each flag by writing 0 to its bit. An interrupt line is raised when an enabled flag is set. Checksums and the lane driver sit outside this block.

Top module: `cmdq_issuer`

Register word addresses: 0 start (bit 0), 1 mode (bits 1:0), 2 interrupt enable (bit 0 read-ready, bit 1 done), 3 status, 4 queue size (bits 5:0), 5 acknowledge (bit 0), 8 to 11 receive words, and 32 to 47 queue words 0 to 15.

## Requirements
- R1: After reset, the status register reads 0, tx_valid is low and irq is low.
- R2: A packet whose queue word 0 has config bit 1 clear is short. It is sent as exactly three bytes: word0[15:8], word0[23:16], word0[31:24]. tx_last is high on the third byte.
- R3: A packet with config bit 1 set is long. It is sent as word0[15:8], then the count low byte, then the count high byte (count = word0[31:16]), then count payload bytes. Payload byte k is byte k mod 4, little-endian, of queue word 1 + k/4.
- R4: A payload byte whose queue word index is not below the 6-bit queue-size value, which was latched at start, is sent as 0x00. The queue-size register keeps only its low 6 bits.
- R5: A launch happens only when a write sets start bit 0 while the stored start bit is 0. Writing 1 again without first writing 0 sends nothing.
- R6: When the mode register is non-zero (not command mode), a start edge is rejected: no byte is sent and status is unchanged.
- R7: Status bit 31 (busy) is set from the cycle after launch until acknowledge. Start edges while busy send nothing extra.
- R8: Status bit 1 (done) is set in the cycle after the last byte. A status write clears each flag whose written bit is 0 and keeps each flag whose written bit is 1.
- R9: Config bit 2 raises tx_turn together with tx_last. Receive bytes are then stored in order into a 16-byte buffer (receive word w = bytes 4w..4w+3, little-endian), and bytes beyond 16 are dropped. Status bit 0 (read-ready) is set after the byte marked rx_last. Receive bytes are ignored at any other time, and each launch clears the buffer.
- R10: An acknowledge write (bit 0 = 1) returns the block to idle only after the packet, and for a read the response, has completed. An earlier acknowledge has no effect.
- R11: irq is high exactly when (done and enable bit 1) or (read-ready and enable bit 0) is true.
- R12: A long packet with a count of 0 is sent as its three header bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write word address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | ADDR_W | Register read word address |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Packet byte valid |
| tx_byte | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_turn | output | 1 | Bus turnaround requested after this byte |
| rx_valid | input | 1 | Response byte valid |
| rx_byte | input | 8 | Response byte |
| rx_last | input | 1 | Final response byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A long count larger than the words covered by the queue size: a design that read past the size would emit stale queue data instead of zeros.
- A zero-length long packet: an off-by-one in the final-byte test would send an extra byte or stall.
- A repeated start without the intervening 0, a start in a non-command mode, and a start or acknowledge arriving mid-packet: each would otherwise spawn a duplicate packet or drop busy too early.
- A read whose response overruns the 16-byte buffer, together with stray receive bytes before the read: a design that wraps its index or captures outside the response window would corrupt the first receive word.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_SEND     = 2'd1,
        SEQ_WAIT_RX  = 2'd2,
        SEQ_WAIT_ACK = 2'd3
    } seq_state_e;

    localparam int REG_START   = 0;
    localparam int REG_MODE    = 1;
    localparam int REG_IRQ_EN  = 2;
    localparam int REG_STATUS  = 3;
    localparam int REG_QSIZE   = 4;
    localparam int REG_ACK     = 5;
    localparam int REG_RX_BASE = 8;

    localparam int CFG_LONG  = 1;
    localparam int CFG_TURN  = 2;

    localparam int STAT_RDY  = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_BUSY = 31;

    localparam int QSIZE_W   = 6;
    localparam int WC_W      = 16;
    localparam int HDR_BYTES = 3;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [31:0]      rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [31:0]      rd_b_data
);
    logic [DEPTH*32-1:0] words_flat;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [31:0] word_d, word_q;
        always_comb begin
            word_d = word_q;
            if (wr_en && wr_idx == IDX_W'(w)) word_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end
        assign words_flat[w*32 +: 32] = word_q;
    end

    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (rd_a_idx == IDX_W'(w)) rd_a_data = words_flat[w*32 +: 32];
            if (rd_b_idx == IDX_W'(w)) rd_b_data = words_flat[w*32 +: 32];
        end
    end
endmodule

// File: rtl/cmdq_rx_capture.sv
module cmdq_rx_capture #(
    parameter int RX_BYTES = 16,
    parameter int CNT_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  take,
    input  logic [7:0]            rx_byte,
    output logic [RX_BYTES*8-1:0] rx_flat
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                                     cnt_d = '0;
        else if (take && cnt_q < CNT_W'(RX_BYTES))     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar b = 0; b < RX_BYTES; b++) begin : g_byte
        logic [7:0] byte_d, byte_q;
        always_comb begin
            byte_d = byte_q;
            if (clear)                             byte_d = '0;
            else if (take && cnt_q == CNT_W'(b))   byte_d = rx_byte;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) byte_q <= '0;
            else        byte_q <= byte_d;
        end
        assign rx_flat[b*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/cmdq_tx_seq.sv
module cmdq_tx_seq
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [QSIZE_W-1:0] qsize,
    input  logic [31:0]        rd_data,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic               rx_valid,
    input  logic               rx_last,
    input  logic               ack,
    output logic               tx_valid,
    output logic [7:0]         tx_byte,
    output logic               tx_last,
    output logic               tx_turn,
    output logic               busy,
    output logic               rx_window,
    output logic               done_set,
    output logic               rdy_set
);
    localparam int CNT_W = WC_W + 1;

    typedef struct packed {
        seq_state_e         st;
        logic               is_long;
        logic               turn;
        logic [7:0]         dt;
        logic [15:0]        arg;
        logic [QSIZE_W-1:0] qsz;
        logic [CNT_W-1:0]   idx;
    } seq_t;

    seq_t s_d, s_q;

    logic [CNT_W-1:0] last_idx, pay_off, word_sel;
    logic             is_final, word_ok;

    always_comb begin
        last_idx = s_q.is_long ? CNT_W'(s_q.arg) + CNT_W'(HDR_BYTES - 1)
                               : CNT_W'(HDR_BYTES - 1);
        is_final = (s_q.idx == last_idx);
        pay_off  = s_q.idx - CNT_W'(HDR_BYTES);
        word_sel = {2'b00, pay_off[CNT_W-1:2]} + CNT_W'(1);
        word_ok  = (word_sel < CNT_W'(s_q.qsz)) && (word_sel < CNT_W'(DEPTH));
        rd_idx   = (s_q.st == SEQ_SEND && word_ok) ? word_sel[IDX_W-1:0] : '0;

        case (s_q.idx)
            CNT_W'(0): tx_byte = s_q.dt;
            CNT_W'(1): tx_byte = s_q.arg[7:0];
            CNT_W'(2): tx_byte = s_q.arg[15:8];
            default:   tx_byte = word_ok ? rd_data[pay_off[1:0]*8 +: 8] : 8'h00;
        endcase

        tx_valid  = (s_q.st == SEQ_SEND);
        tx_last   = tx_valid && is_final;
        tx_turn   = tx_last && s_q.turn;
        busy      = (s_q.st != SEQ_IDLE);
        rx_window = (s_q.st == SEQ_WAIT_RX);

        s_d      = s_q;
        done_set = 1'b0;
        rdy_set  = 1'b0;
        case (s_q.st)
            SEQ_IDLE: begin
                if (launch) begin
                    s_d.st      = SEQ_SEND;
                    s_d.is_long = rd_data[CFG_LONG];
                    s_d.turn    = rd_data[CFG_TURN];
                    s_d.dt      = rd_data[15:8];
                    s_d.arg     = rd_data[31:16];
                    s_d.qsz     = qsize;
                    s_d.idx     = '0;
                end
            end
            SEQ_SEND: begin
                if (is_final) begin
                    done_set = 1'b1;
                    s_d.st   = s_q.turn ? SEQ_WAIT_RX : SEQ_WAIT_ACK;
                end else begin
                    s_d.idx = s_q.idx + CNT_W'(1);
                end
            end
            SEQ_WAIT_RX: begin
                if (rx_valid && rx_last) begin
                    rdy_set = 1'b1;
                    s_d.st  = SEQ_WAIT_ACK;
                end
            end
            default: begin
                if (ack) s_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cmdq_issuer.sv
module cmdq_issuer
    import cmdq_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 6,
    parameter int QUEUE_BASE = 32,
    parameter int RX_BYTES   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    output logic              tx_turn,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic              irq
);
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RX_WORDS = RX_BYTES / 4;
    localparam int RX_CNT_W = $clog2(RX_BYTES) + 1;
    localparam int QEND     = QUEUE_BASE + DEPTH;

    typedef struct packed {
        logic               start;
        logic [1:0]         mode;
        logic [1:0]         irq_en;
        logic [QSIZE_W-1:0] qsize;
        logic               done;
        logic               rdy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              wr_start, wr_mode, wr_en_reg, wr_status, wr_qsize, wr_ack;
    logic              q_wr_hit, q_rd_hit, launch, ack;
    logic [IDX_W-1:0]  q_wr_idx, q_rd_idx, seq_rd_idx;
    logic [31:0]       seq_rd_data, bus_rd_data;
    logic              busy, rx_window, done_set, rdy_set;
    logic [RX_BYTES*8-1:0] rx_flat;
    logic              stat_done, stat_rdy, mode_cmd;
    logic [1:0]        irq_en_w;

    always_comb begin
        wr_start  = reg_wr_en && reg_waddr == ADDR_W'(REG_START);
        wr_mode   = reg_wr_en && reg_waddr == ADDR_W'(REG_MODE);
        wr_en_reg = reg_wr_en && reg_waddr == ADDR_W'(REG_IRQ_EN);
        wr_status = reg_wr_en && reg_waddr == ADDR_W'(REG_STATUS);
        wr_qsize  = reg_wr_en && reg_waddr == ADDR_W'(REG_QSIZE);
        wr_ack    = reg_wr_en && reg_waddr == ADDR_W'(REG_ACK);

        q_wr_hit  = reg_wr_en && ({1'b0, reg_waddr} >= (ADDR_W+1)'(QUEUE_BASE))
                              && ({1'b0, reg_waddr} <  (ADDR_W+1)'(QEND));
        q_rd_hit  = ({1'b0, reg_raddr} >= (ADDR_W+1)'(QUEUE_BASE))
                 && ({1'b0, reg_raddr} <  (ADDR_W+1)'(QEND));
        q_wr_idx  = IDX_W'(reg_waddr - ADDR_W'(QUEUE_BASE));
        q_rd_idx  = IDX_W'(reg_raddr - ADDR_W'(QUEUE_BASE));

        launch    = wr_start && reg_wdata[0] && !ctl_q.start && (ctl_q.mode == 2'd0);
        ack       = wr_ack && reg_wdata[0];

        ctl_d = ctl_q;
        if (wr_start)  ctl_d.start  = reg_wdata[0];
        if (wr_mode)   ctl_d.mode   = reg_wdata[1:0];
        if (wr_en_reg) ctl_d.irq_en = reg_wdata[1:0];
        if (wr_qsize)  ctl_d.qsize  = reg_wdata[QSIZE_W-1:0];
        if (wr_status) begin
            ctl_d.done = ctl_q.done & reg_wdata[STAT_DONE];
            ctl_d.rdy  = ctl_q.rdy  & reg_wdata[STAT_RDY];
        end
        ctl_d.done = ctl_d.done | done_set;
        ctl_d.rdy  = ctl_d.rdy  | rdy_set;

        irq = (ctl_q.done & ctl_q.irq_en[STAT_DONE]) | (ctl_q.rdy & ctl_q.irq_en[STAT_RDY]);

        stat_done = ctl_q.done;
        stat_rdy  = ctl_q.rdy;
        mode_cmd  = (ctl_q.mode == 2'd0);
        irq_en_w  = ctl_q.irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == ADDR_W'(REG_START))  reg_rdata[0]           = ctl_q.start;
        if (reg_raddr == ADDR_W'(REG_MODE))   reg_rdata[1:0]         = ctl_q.mode;
        if (reg_raddr == ADDR_W'(REG_IRQ_EN)) reg_rdata[1:0]         = ctl_q.irq_en;
        if (reg_raddr == ADDR_W'(REG_QSIZE))  reg_rdata[QSIZE_W-1:0] = ctl_q.qsize;
        if (reg_raddr == ADDR_W'(REG_STATUS)) begin
            reg_rdata[STAT_BUSY] = busy;
            reg_rdata[STAT_DONE] = ctl_q.done;
            reg_rdata[STAT_RDY]  = ctl_q.rdy;
        end
        for (int w = 0; w < RX_WORDS; w++) begin
            if (reg_raddr == ADDR_W'(REG_RX_BASE + w)) reg_rdata = rx_flat[w*32 +: 32];
        end
        if (q_rd_hit) reg_rdata = bus_rd_data;
    end

    cmdq_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (q_wr_hit),
        .wr_idx    (q_wr_idx),
        .wr_data   (reg_wdata),
        .rd_a_idx  (seq_rd_idx),
        .rd_a_data (seq_rd_data),
        .rd_b_idx  (q_rd_idx),
        .rd_b_data (bus_rd_data)
    );

    cmdq_tx_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .qsize     (ctl_q.qsize),
        .rd_data   (seq_rd_data),
        .rd_idx    (seq_rd_idx),
        .rx_valid  (rx_valid),
        .rx_last   (rx_last),
        .ack       (ack),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_last   (tx_last),
        .tx_turn   (tx_turn),
        .busy      (busy),
        .rx_window (rx_window),
        .done_set  (done_set),
        .rdy_set   (rdy_set)
    );

    cmdq_rx_capture #(.RX_BYTES(RX_BYTES), .CNT_W(RX_CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch && !busy),
        .take    (rx_window && rx_valid),
        .rx_byte (rx_byte),
        .rx_flat (rx_flat)
    );
endmodule

// File: rtl/cmdq_issuer_chk.sv
module cmdq_issuer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_valid,
    input logic       tx_last,
    input logic       tx_turn,
    input logic       rx_valid,
    input logic       rx_last,
    input logic       irq,
    input logic       busy,
    input logic       done_flag,
    input logic       rdy_flag,
    input logic       mode_cmd,
    input logic [1:0] irq_en
);
    assert_last_has_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    assert_turn_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_turn |-> (tx_valid && tx_last));

    assert_busy_while_sending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_last && !tx_turn) |=> (done_flag && busy));

    assert_reject_non_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !mode_cmd) |=> !tx_valid);

    assert_rdy_from_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_flag) |-> $past(rx_valid && rx_last));

    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);
endmodule

bind cmdq_issuer cmdq_issuer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_turn   (tx_turn),
    .rx_valid  (rx_valid),
    .rx_last   (rx_last),
    .irq       (irq),
    .busy      (busy),
    .done_flag (stat_done),
    .rdy_flag  (stat_rdy),
    .mode_cmd  (mode_cmd),
    .irq_en    (irq_en_w)
);

// File: tb/tb_cmdq_issuer.sv
module tb_cmdq_issuer;
    localparam int A_START = 0, A_MODE = 1, A_EN = 2, A_STAT = 3, A_QSIZE = 4, A_ACK = 5;
    localparam int A_RX = 8, A_Q = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [5:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_last, tx_turn, irq;
    logic [7:0]  tx_byte;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_byte = '0;

    int checks = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cmdq_issuer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last), .tx_turn(tx_turn),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last), .irq(irq)
    );

    // behavioural reference model
    int          m_state;
    logic [7:0]  m_bytes[$];
    bit          m_turn, m_startq, m_done, m_rdy;
    logic [1:0]  m_mode, m_en;
    logic [5:0]  m_qsize;
    logic [31:0] m_q[16];
    logic [7:0]  m_rx[16];
    int          m_rxcnt;
    int          os;
    bit          d_set, r_set, do_launch;
    logic [31:0] w0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_bytes.delete(); m_turn = 0; m_startq = 0; m_done = 0; m_rdy = 0;
            m_mode = 0; m_en = 0; m_qsize = 0; m_rxcnt = 0;
            for (int i = 0; i < 16; i++) begin m_q[i] = 0; m_rx[i] = 0; end
        end else begin
            os = m_state; d_set = 0; r_set = 0;
            do_launch = reg_wr_en && reg_waddr == A_START && reg_wdata[0] && !m_startq
                        && m_mode == 0 && os == 0;
            if (os == 1) begin
                void'(m_bytes.pop_front());
                if (m_bytes.size() == 0) begin d_set = 1; m_state = m_turn ? 2 : 3; end
            end else if (os == 2) begin
                if (rx_valid) begin
                    if (m_rxcnt < 16) m_rx[m_rxcnt] = rx_byte;
                    m_rxcnt++;
                    if (rx_last) begin r_set = 1; m_state = 3; end
                end
            end else if (os == 3) begin
                if (reg_wr_en && reg_waddr == A_ACK && reg_wdata[0]) m_state = 0;
            end
            if (reg_wr_en) begin
                if (reg_waddr == A_START) m_startq = reg_wdata[0];
                if (reg_waddr == A_MODE)  m_mode = reg_wdata[1:0];
                if (reg_waddr == A_EN)    m_en = reg_wdata[1:0];
                if (reg_waddr == A_QSIZE) m_qsize = reg_wdata[5:0];
                if (reg_waddr == A_STAT) begin
                    m_done = m_done & reg_wdata[1];
                    m_rdy  = m_rdy & reg_wdata[0];
                end
                if (reg_waddr >= A_Q && reg_waddr < A_Q + 16) m_q[reg_waddr - A_Q] = reg_wdata;
            end
            m_done = m_done | d_set;
            m_rdy  = m_rdy | r_set;
            if (do_launch) begin
                w0 = m_q[0];
                m_turn = w0[2];
                m_bytes.delete();
                m_bytes.push_back(w0[15:8]);
                m_bytes.push_back(w0[23:16]);
                m_bytes.push_back(w0[31:24]);
                if (w0[1]) begin
                    for (int k = 0; k < int'(w0[31:16]); k++) begin
                        int wi;
                        wi = 1 + k / 4;
                        if (wi < int'(m_qsize) && wi < 16)
                            m_bytes.push_back(8'(m_q[wi] >> (8 * (k % 4))));
                        else
                            m_bytes.push_back(8'h00);
                    end
                end
                for (int i = 0; i < 16; i++) m_rx[i] = 0;
                m_rxcnt = 0;
                m_state = 1;
            end
        end
    end

    // per-clock comparison and byte collection
    logic [7:0] got[$];
    bit         last_turn;
    bit         ev, el, et, ei;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            ev = (m_state == 1);
            el = ev && m_bytes.size() == 1;
            et = el && m_turn;
            ei = (m_done && m_en[1]) || (m_rdy && m_en[0]);
            checks++;
            if (tx_valid !== ev || irq !== ei || (ev && (tx_byte !== m_bytes[0] ||
                tx_last !== el || tx_turn !== et))) begin
                bad++;
                $display("FAIL stream R2 R3 R4 R9 R11: got v=%b b=%h l=%b t=%b irq=%b exp v=%b b=%h l=%b t=%b irq=%b",
                         tx_valid, tx_byte, tx_last, tx_turn, irq, ev,
                         ev ? m_bytes[0] : 8'h00, el, et, ei);
            end
            if (tx_valid) begin
                got.push_back(tx_byte);
                if (tx_last) last_turn = tx_turn;
            end
        end
    end

    logic [7:0] exp_q[$];

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_waddr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_raddr = 6'(a);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic cmp_bytes(input string tag);
        checks++;
        if (got.size() != exp_q.size()) begin
            bad++;
            $display("FAIL %s: actual count=%0d expected count=%0d", tag, got.size(), exp_q.size());
        end else begin
            for (int i = 0; i < exp_q.size(); i++) begin
                if (got[i] !== exp_q[i]) begin
                    bad++;
                    $display("FAIL %s: byte %0d actual=%h expected=%h", tag, i, got[i], exp_q[i]);
                    break;
                end
            end
        end
        got.delete();
    endtask

    task automatic kick();
        wr(A_START, 0);
        wr(A_START, 1);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit last);
        @(negedge clk);
        rx_valid = 1; rx_byte = b; rx_last = last;
        @(negedge clk);
        rx_valid = 0; rx_last = 0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(A_STAT, 32'h0, "R1 status");
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        wr(A_EN, 3);

        // R2 short packet
        wr(A_Q + 0, {8'hB2, 8'hA1, 8'h05, 8'h00});
        kick(); idle(6);
        exp_q = {8'h05, 8'hA1, 8'hB2}; cmp_bytes("R2 short bytes");
        chk("R2 no turn", {31'b0, last_turn}, 0);
        rd_chk(A_STAT, 32'h8000_0002, "R7 R8 busy and done");
        chk("R11 irq on done", {31'b0, irq}, 1);
        wr(A_ACK, 1);
        rd_chk(A_STAT, 32'h0000_0002, "R10 ack releases");
        wr(A_STAT, 32'h1);
        rd_chk(A_STAT, 32'h0, "R8 write 0 clears done");
        chk("R11 irq low", {31'b0, irq}, 0);

        // R3 long packet
        wr(A_Q + 0, {16'd7, 8'h39, 8'h02});
        wr(A_Q + 1, 32'h4433_2211);
        wr(A_Q + 2, 32'h8877_6655);
        wr(A_QSIZE, 3);
        kick(); idle(14);
        exp_q = {8'h39, 8'h07, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
        cmp_bytes("R3 long bytes");
        wr(A_ACK, 1); wr(A_STAT, 0);

        // R4 payload past queue size is zero; size keeps 6 bits
        wr(A_Q + 0, {16'd10, 8'h29, 8'h02});
        wr(A_QSIZE, 32'hC2);
        rd_chk(A_QSIZE, 32'h2, "R4 qsize 6 bits");
        kick(); idle(16);
        exp_q = {8'h29, 8'h0A, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44,
                 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        cmp_bytes("R4 zero fill");
        wr(A_ACK, 1); wr(A_STAT, 0);

        // R12 zero-length long packet
        wr(A_Q + 0, {16'd0, 8'h19, 8'h02});
        kick(); idle(6);
        exp_q = {8'h19, 8'h00, 8'h00}; cmp_bytes("R12 header only");
        rd_chk(A_STAT, 32'h8000_0002, "R12 done");
        wr(A_ACK, 1); wr(A_STAT, 0);

        // R5 start 1 again without 0
        wr(A_START, 1); idle(6);
        exp_q = {}; cmp_bytes("R5 no relaunch");
        rd_chk(A_STAT, 32'h0, "R5 idle");

        // R6 non-command mode rejects
        wr(A_MODE, 2);
        kick(); idle(6);
        exp_q = {}; cmp_bytes("R6 rejected");
        rd_chk(A_STAT, 32'h0, "R6 status untouched");
        wr(A_MODE, 0);

        // R7 R10 start and ack during packet
        wr(A_Q + 0, {8'h22, 8'h11, 8'h15, 8'h00});
        kick();
        wr(A_ACK, 1);
        kick(); idle(6);
        exp_q = {8'h15, 8'h11, 8'h22}; cmp_bytes("R7 single packet");
        rd_chk(A_STAT, 32'h8000_0002, "R10 early ack ignored");
        kick(); idle(4);
        exp_q = {}; cmp_bytes("R7 start while busy");
        wr(A_ACK, 1); wr(A_STAT, 0);

        // R9 read with turnaround
        send_rx(8'hEE, 1);
        rd_chk(A_STAT, 32'h0, "R9 stray rx ignored");
        wr(A_Q + 0, {8'h00, 8'h0A, 8'h06, 8'h04});
        kick(); idle(6);
        exp_q = {8'h06, 8'h0A, 8'h00}; cmp_bytes("R9 read bytes");
        chk("R9 turn on last", {31'b0, last_turn}, 1);
        rd_chk(A_STAT, 32'h8000_0002, "R9 waiting for response");
        wr(A_ACK, 1);
        rd_chk(A_STAT, 32'h8000_0002, "R10 ack before response ignored");
        for (int i = 0; i < 18; i++) send_rx(8'(8'hC0 + i), i == 17);
        rd_chk(A_RX + 0, 32'hC3C2_C1C0, "R9 rx word 0");
        rd_chk(A_RX + 3, 32'hCFCE_CDCC, "R9 rx word 3 no overrun");
        rd_chk(A_STAT, 32'h8000_0003, "R9 read ready");
        wr(A_ACK, 1);
        wr(A_STAT, 32'h2);
        rd_chk(A_STAT, 32'h2, "R8 clear rdy keep done");

        // R11 enable masking
        wr(A_EN, 1); idle(1);
        chk("R11 done masked", {31'b0, irq}, 0);
        wr(A_EN, 2); idle(1);
        chk("R11 done enabled", {31'b0, irq}, 1);
        wr(A_STAT, 0); idle(2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule